// File: doc/BRIEF.md
# Single-Channel DMA Byte Mover

This block is one DMA channel. It copies a programmed number of bytes from a source to a destination. Each side has its own two-bit addressing mode. The side can be memory whose address counts up, memory whose address counts down, memory at a fixed address (which also serves memory-mapped peripherals), or a port in I/O space at a fixed address. Software loads the two start addresses, the byte count and a control word through a small write port, and the last of these writes sets the enable bit. The channel then asks for the bus and moves each byte as one read cycle followed by one write cycle. Between the two cycles the byte sits in an internal holding register.

When both sides are memory, a mode bit sets the timing. In burst timing the channel keeps the bus until the last byte is written. In cycle-steal timing it drops its bus request for one cycle after every byte, which gives the processor a cycle. When either side is I/O, the DREQ input paces the bytes instead and the mode bit has no effect. When the count reaches zero the channel clears its enable bit, drops the bus and pulses `done` for one clock.

Top module: `dma_channel`

## Requirements
- R1: The mode codes are the same for source and destination: 00 is memory with the address plus 1 after each access to that side, 01 is memory with the address minus 1, 10 is memory at a fixed address and 11 is I/O at a fixed address. `mem_io` is high on an access exactly when that side's mode is 11. Read back through the register port, each address register ends at start + step × bytes moved, where step is +1, -1 or 0 for its mode.
- R2: Each byte is a single-cycle read at the source address (`mem_rd`), then in the very next cycle a single-cycle write at the destination address (`mem_wr`). The write drives the data byte that the read returned. `mem_rd` and `mem_wr` are never high together.
- R3: The byte count drops by one per write. When it reaches zero the enable bit (control bit 5) reads back 0 and `bus_req` is low in the cycle where `done` is high. `done` is high for exactly one clock per transfer. The mode fields keep their values.
- R4: Burst timing. Control bit 4 is 1 and both modes are below 11. `bus_req` stays high from its rise until the last write, and the next read follows each write in the very next cycle.
- R5: Cycle-steal timing. Control bit 4 is 0 and both modes are below 11. After every write except the last, `bus_req` is low for exactly one cycle, so an N-byte transfer has N-1 such cycles.
- R6: In memory-to-memory transfers the `dreq` input has no effect on the order of accesses, their addresses, their data or the number of cycles with `bus_req` low.
- R7: When either mode is 11, a byte starts only if `dreq` was high at the preceding clock edge. While `dreq` is low between bytes, `bus_req` stays low. Control bit 4 makes no difference to the accesses.
- R8: If the count is zero when the channel becomes enabled, `done` pulses in the cycle after enable, the enable bit clears, and no read or write cycle occurs.
- R9: `bus_req` rises and stays high until `bus_gnt` is seen. No read or write happens before the grant, whatever the grant latency.
- R10: After reset, all four registers read 0, `bus_req`, `mem_rd`, `mem_wr` and `done` are low.

Register select (`cfg_sel`): 0 source address, 1 destination address, 2 byte count, 3 control. The control word holds bits [1:0] source mode, [3:2] destination mode, [4] memory timing (1 burst, 0 cycle steal) and [5] enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read-back |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Read-back of the selected register |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant, held while the request is high |
| dreq | input | 1 | Level-sensitive pacing request for transfers with an I/O side |
| mem_addr | output | ADDR_W | Address of the current access |
| mem_io | output | 1 | Current access targets I/O space |
| mem_rd | output | 1 | Read cycle strobe |
| mem_wr | output | 1 | Write cycle strobe |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, sampled at the end of the read cycle |
| done | output | 1 | One-clock completion pulse |

## Verification
Some rules are checked by properties on every cycle. These are the one-step moves of each address register for its mode, and that reads and writes never overlap. They also cover a write always following a read, and accesses only under grant. Further cycle rules are the back-to-back read after a burst write, the single dropped request after a cycle-steal write, and no request while `dreq` is low on an I/O transfer. The end of a transfer is checked too: a one-clock `done` with the enable already clear, and no access when the count is zero. Only the bench's sweep over every mode pair, both timing settings and several counts and grant latencies can show the rest. That covers the data actually carried from source to destination, the final addresses and count read back, and the exact number of cycles the bus is given up.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        XM_INC = 2'b00,
        XM_DEC = 2'b01,
        XM_FIX = 2'b10,
        XM_IO  = 2'b11
    } xfer_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_RD,
        ST_WR,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CNT  = 2'd2;
    localparam logic [1:0] SEL_CTRL = 2'd3;

endpackage

// File: rtl/dma_addr_ptr.sv
module dma_addr_ptr
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  xfer_mode_e        mode,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load) begin
            addr_d = load_val;
        end else if (step) begin
            case (mode)
                XM_INC:  addr_d = addr_q + ADDR_W'(1);
                XM_DEC:  addr_d = addr_q - ADDR_W'(1);
                default: addr_d = addr_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R1: fixed and I/O sides never move
    a_r1_fixed_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode[1]) |=> $stable(addr_q));
    // R1: counting sides move by exactly one
    a_r1_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == XM_INC) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));
    a_r1_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && mode == XM_DEC) |=> (addr_q == $past(addr_q) - ADDR_W'(1)));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cnt_zero,
    input  logic       cnt_one,
    input  xfer_mode_e src_mode,
    input  xfer_mode_e dst_mode,
    input  logic       burst_sel,
    input  logic       dreq,
    input  logic       bus_gnt,
    output logic       bus_req,
    output logic       rd,
    output logic       wr,
    output logic       finish,
    output logic       done
);

    typedef struct packed {
        seq_state_e state;
        logic       done;
    } seq_regs_t;

    seq_regs_t s_d, s_q;
    logic      io_path;
    logic      burst;

    assign io_path = (src_mode == XM_IO) || (dst_mode == XM_IO);
    assign burst   = !io_path && burst_sel;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        finish   = 1'b0;
        bus_req  = 1'b0;
        rd       = 1'b0;
        wr       = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (en) begin
                    if (cnt_zero) begin
                        finish   = 1'b1;
                        s_d.done = 1'b1;
                    end else if (!io_path || dreq) begin
                        s_d.state = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                bus_req = 1'b1;
                if (bus_gnt) s_d.state = ST_RD;
            end
            ST_RD: begin
                bus_req   = 1'b1;
                rd        = 1'b1;
                s_d.state = ST_WR;
            end
            ST_WR: begin
                bus_req = 1'b1;
                wr      = 1'b1;
                if (cnt_one) begin
                    finish    = 1'b1;
                    s_d.done  = 1'b1;
                    s_d.state = ST_IDLE;
                end else if (io_path) begin
                    s_d.state = dreq ? ST_RD : ST_IDLE;
                end else if (burst) begin
                    s_d.state = ST_RD;
                end else begin
                    s_d.state = ST_GAP;
                end
            end
            ST_GAP:  s_d.state = ST_REQ;
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, done: 1'b0};
        else        s_q <= s_d;
    end

    assign done = s_q.done;

    // R4: burst writes are followed at once by the next read
    a_r4_burst_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && burst && !cnt_one) |=> rd);
    // R5: cycle steal gives up the bus for one cycle after each byte
    a_r5_steal_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !io_path && !burst_sel && !cnt_one) |=> (!bus_req ##1 bus_req));
    // R7: no request while pacing input is low between bytes
    a_r7_wait_off_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (io_path && !bus_req && !dreq) |=> !bus_req);
    // R9: accesses only under grant
    a_r9_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd) && !$past(rd) && !$past(wr) |-> $past(bus_gnt));
    // R3: done is a single-clock pulse
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              dreq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_io,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done
);

    localparam int NPTR   = 2;
    localparam int CTRL_W = 6;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        xfer_mode_e        smode;
        xfer_mode_e        dmode;
        logic              burst_sel;
        logic              en;
        logic [DATA_W-1:0] hold;
    } chan_regs_t;

    chan_regs_t r_d, r_q;
    logic       rd, wr, finish;

    logic [ADDR_W-1:0] ptr_addr [NPTR];
    logic              ptr_load [NPTR];
    logic              ptr_step [NPTR];
    xfer_mode_e        ptr_mode [NPTR];

    assign ptr_load[0] = cfg_we && (cfg_sel == SEL_SRC);
    assign ptr_load[1] = cfg_we && (cfg_sel == SEL_DST);
    assign ptr_step[0] = rd;
    assign ptr_step[1] = wr;
    assign ptr_mode[0] = r_q.smode;
    assign ptr_mode[1] = r_q.dmode;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        dma_addr_ptr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (ptr_load[g]),
            .load_val (cfg_wdata),
            .step     (ptr_step[g]),
            .mode     (ptr_mode[g]),
            .addr     (ptr_addr[g])
        );
    end

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (r_q.en),
        .cnt_zero  (r_q.cnt == '0),
        .cnt_one   (r_q.cnt == CNT_W'(1)),
        .src_mode  (r_q.smode),
        .dst_mode  (r_q.dmode),
        .burst_sel (r_q.burst_sel),
        .dreq      (dreq),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .rd        (rd),
        .wr        (wr),
        .finish    (finish),
        .done      (done)
    );

    always_comb begin
        r_d = r_q;
        if (rd) r_d.hold = mem_rdata;
        if (wr) r_d.cnt = r_q.cnt - CNT_W'(1);
        if (cfg_we) begin
            case (cfg_sel)
                SEL_CNT:  r_d.cnt = cfg_wdata[CNT_W-1:0];
                SEL_CTRL: begin
                    r_d.smode     = xfer_mode_e'(cfg_wdata[1:0]);
                    r_d.dmode     = xfer_mode_e'(cfg_wdata[3:2]);
                    r_d.burst_sel = cfg_wdata[4];
                    r_d.en        = cfg_wdata[5];
                end
                default: ;
            endcase
        end
        if (finish) r_d.en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{cnt: '0, smode: XM_INC, dmode: XM_INC,
                             burst_sel: 1'b0, en: 1'b0, hold: '0};
        else        r_q <= r_d;
    end

    always_comb begin
        case (cfg_sel)
            SEL_SRC: cfg_rdata = ptr_addr[0];
            SEL_DST: cfg_rdata = ptr_addr[1];
            SEL_CNT: cfg_rdata = ADDR_W'(r_q.cnt);
            default: cfg_rdata = {{(ADDR_W-CTRL_W){1'b0}}, r_q.en, r_q.burst_sel,
                                  r_q.dmode, r_q.smode};
        endcase
    end

    assign mem_rd    = rd;
    assign mem_wr    = wr;
    assign mem_addr  = rd ? ptr_addr[0] : ptr_addr[1];
    assign mem_io    = rd ? (r_q.smode == XM_IO) : (r_q.dmode == XM_IO);
    assign mem_wdata = r_q.hold;

    // R2: read and write never share a cycle, and a write follows a read
    a_r2_rw_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);
    // R3: enable is already clear when done shows, bus released
    a_r3_done_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!r_q.en && !bus_req));
    // R8: empty count never touches the bus
    a_r8_zero_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && r_q.cnt == '0) |-> !(mem_rd || mem_wr));
    // R9: accesses only while granted
    a_r9_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (bus_gnt && bus_req));

endmodule

// File: tb/tb_dma_channel.sv
module tb_dma_channel;

    localparam int AW = 16;
    localparam int CW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] cfg_rdata;
    logic          bus_req, bus_gnt, dreq;
    logic [AW-1:0] mem_addr;
    logic          mem_io, mem_rd, mem_wr, done;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #4 clk = ~clk;

    dma_channel #(.ADDR_W(AW), .CNT_W(CW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .dreq(dreq), .mem_addr(mem_addr), .mem_io(mem_io),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .done(done)
    );

    int checks = 0;
    int fails  = 0;
    bit all_done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory pattern and I/O source
    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h5A;
    endfunction

    logic [7:0] io_rd_cnt = 8'd0;
    always @(posedge clk) if (mem_rd && mem_io) io_rd_cnt <= io_rd_cnt + 8'd1;
    assign mem_rdata = mem_io ? (8'hC0 + io_rd_cnt) : pat(mem_addr);

    // arbiter with programmable latency
    int gnt_delay = 1;
    int req_run = 0;
    logic gnt_q = 1'b0;
    always @(posedge clk) begin
        if (!bus_req) begin
            req_run <= 0;
            gnt_q   <= 1'b0;
        end else begin
            req_run <= req_run + 1;
            gnt_q   <= (req_run + 1 >= gnt_delay);
        end
    end
    assign bus_gnt = gnt_q;

    // transfer under test
    logic [AW-1:0] t_s0, t_d0;
    logic [1:0]    t_sm, t_dm;
    int            t_n;
    logic [7:0]    t_io_base;
    bit            mon_on = 1'b0;
    logic          dreq_q = 1'b0;
    assign dreq = dreq_q;

    function automatic logic [AW-1:0] stepped(input logic [AW-1:0] b, input logic [1:0] m,
                                              input int i);
        if (m == 2'b00) return b + AW'(i);
        if (m == 2'b01) return b - AW'(i);
        return b;
    endfunction

    function automatic logic [7:0] exp_data(input int i);
        if (t_sm == 2'b11) return t_io_base + 8'hC0 + 8'(i);
        return pat(stepped(t_s0, t_sm, i));
    endfunction

    // per-cycle monitor
    int  m_b, m_idle, m_done, m_acc, cyc = 0;
    bit  m_started, m_fin, prev_rd, prev_req, prev_dreq, prev_done;
    always @(negedge clk) begin
        cyc++;
        if (!mon_on) begin
            m_b = 0; m_idle = 0; m_done = 0; m_acc = 0;
            m_started = 0; m_fin = 0; prev_rd = 0; prev_req = 0; prev_done = 0;
        end else begin
            if (mem_rd || mem_wr) begin
                m_acc++;
                chk(bus_gnt, "R9 access without grant", 32'(bus_gnt), 1);
            end
            if (mem_rd) begin
                chk(mem_addr == stepped(t_s0, t_sm, m_b), "R1 source address",
                    32'(mem_addr), 32'(stepped(t_s0, t_sm, m_b)));
                chk(mem_io == (t_sm == 2'b11), "R1 source io flag", 32'(mem_io),
                    32'(t_sm == 2'b11));
            end
            if (mem_wr) begin
                chk(prev_rd, "R2 write not preceded by read", 32'(prev_rd), 1);
                chk(mem_addr == stepped(t_d0, t_dm, m_b), "R1 destination address",
                    32'(mem_addr), 32'(stepped(t_d0, t_dm, m_b)));
                chk(mem_io == (t_dm == 2'b11), "R1 destination io flag", 32'(mem_io),
                    32'(t_dm == 2'b11));
                chk(mem_wdata == exp_data(m_b), "R2 write data", 32'(mem_wdata),
                    32'(exp_data(m_b)));
                m_b++;
            end
            if (bus_req) m_started = 1;
            if (done) begin
                m_done++;
                m_fin = 1;
                chk(!bus_req, "R3 bus held at done", 32'(bus_req), 0);
                chk(m_b == t_n, "R3 bytes moved at done", 32'(m_b), 32'(t_n));
            end
            if (prev_done) chk(!done, "R3 done wider than one clock", 32'(done), 0);
            if (m_started && !m_fin && !bus_req) m_idle++;
            if ((t_sm == 2'b11 || t_dm == 2'b11) && bus_req && !prev_req)
                chk(prev_dreq, "R7 request without dreq", 32'(prev_dreq), 1);
            prev_rd = mem_rd; prev_req = bus_req; prev_done = done;
        end
        dreq_q = (((cyc * 7) % 11) > 3);
        prev_dreq = dreq_q;
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] sel, output logic [AW-1:0] v);
        cfg_sel = sel;
        #1;
        v = cfg_rdata;
    endtask

    task automatic run(input logic [AW-1:0] s0, input logic [1:0] sm,
                       input logic [AW-1:0] d0, input logic [1:0] dm,
                       input bit mm, input int n, input int dly);
        logic [AW-1:0] v;
        bit io = (sm == 2'b11) || (dm == 2'b11);
        int w;
        gnt_delay = dly;
        t_s0 = s0; t_d0 = d0; t_sm = sm; t_dm = dm; t_n = n;
        cfg_write(2'd0, s0);
        cfg_write(2'd1, d0);
        cfg_write(2'd2, AW'(n));
        t_io_base = io_rd_cnt;
        mon_on = 1'b1;
        cfg_write(2'd3, AW'({1'b1, mm, dm, sm}));
        if (n == 0) begin
            @(negedge clk); #1;
            chk(done, "R8 done one cycle after enable", 32'(done), 1);
        end
        w = 0;
        while (m_done == 0 && w < 600) begin
            @(negedge clk); #1;
            w++;
        end
        chk(m_done == 1, "R3 done count", 32'(m_done), 1);
        repeat (2) @(negedge clk);
        #1;
        chk(m_done == 1, "R3 single done", 32'(m_done), 1);
        chk(m_acc == 2 * n, n == 0 ? "R8 accesses on empty count" : "R2 access count",
            32'(m_acc), 32'(2 * n));
        if (!io && n > 0) begin
            if (mm) chk(m_idle == 0, "R4 burst bus drops", 32'(m_idle), 0);
            else    chk(m_idle == n - 1, "R5 steal gap cycles", 32'(m_idle), 32'(n - 1));
        end
        read_reg(2'd0, v);
        chk(v == stepped(s0, sm, n), "R1 final source", 32'(v), 32'(stepped(s0, sm, n)));
        read_reg(2'd1, v);
        chk(v == stepped(d0, dm, n), "R1 final destination", 32'(v),
            32'(stepped(d0, dm, n)));
        read_reg(2'd2, v);
        chk(v == 0, "R3 final count", 32'(v), 0);
        read_reg(2'd3, v);
        chk(v == AW'({1'b0, mm, dm, sm}), "R3 control after completion", 32'(v),
            32'({1'b0, mm, dm, sm}));
        @(negedge clk);
        mon_on = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        logic [AW-1:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!bus_req && !mem_rd && !mem_wr && !done, "R10 outputs in reset",
            32'({bus_req, mem_rd, mem_wr, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            read_reg(2'(s), v);
            chk(v == 0, "R10 register after reset", 32'(v), 0);
        end
        // sweep; R6 and R7 run with a moving dreq on every transfer
        for (int sm = 0; sm < 4; sm++)
            for (int dm = 0; dm < 4; dm++)
                for (int mm = 0; mm < 2; mm++)
                    for (int k = 0; k < 3; k++) begin
                        int n = (k == 0) ? 0 : (k == 1) ? 1 : 4;
                        run(16'h0020, 2'(sm), 16'h1090, 2'(dm), mm[0], n,
                            ((sm + dm + k) % 2 == 1) ? 3 : 1);
                    end
        // longer bursts and steals across address wrap
        run(16'hFFFE, 2'b00, 16'h0001, 2'b01, 1'b1, 7, 2);
        run(16'h0003, 2'b01, 16'hFFFD, 2'b00, 1'b0, 6, 1);
        all_done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!all_done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule